// File: doc/BRIEF.md
# Timer Control Register with Least-Privilege Trap Check

This block holds the kernel-level control word for the system timers. Privileged software reads and writes it through a simple request port. The same word also decides which timer and counter registers the least-privileged level (EL0) may reach. A request from EL0 to the control word itself is flagged as undefined and changes nothing. A request from EL1, EL2 or EL3 reads the word or replaces it.

A second, purely combinational path takes the current level and the identifier of a timer or counter register that an EL0 access is aimed at. It reports whether that access must trap. Access to the frequency register traps only when both the physical-counter enable and the virtual-counter enable are clear, so those two controls are linked.

The event-stream fields (enable, edge direction, trigger bit select) are stored here and driven out unchanged to the block that generates events.

Top module: `tmr_kctl_guard`

## Requirements
- R1: After reset all ten writable bits are 0: a privileged read returns 0, every EL0 timer or counter access traps, and the event enable output is 0.
- R2: A write request (req_valid=1, req_write=1) at level 1, 2 or 3 stores req_wdata[9:0], and a read request at those levels returns the stored word on rd_data in the same cycle. The new value is readable from the cycle after the write edge.
- R3: rd_data[31:10] always reads 0, and whatever is written to bits 31:10 is discarded.
- R4: ctl_undef is 1 exactly when req_valid=1 and cur_lvl=0 (level encoding 0..3 = EL0..EL3), for a read or a write.
- R5: A write from level 0 leaves the stored word unchanged, and a read from level 0 returns rd_data=0.
- R6: At level 0, targets 3, 4 and 5 (physical timer control, compare value, timer value) trap exactly when bit 9 is 0.
- R7: At level 0, targets 6, 7 and 8 (virtual timer control, compare value, timer value) trap exactly when bit 8 is 0.
- R8: At level 0, target 1 (physical counter) traps exactly when bit 0 is 0, and target 2 (virtual counter) traps exactly when bit 1 is 0.
- R9: At level 0, target 0 (frequency register) traps only when bits 0 and 1 are both 0.
- R10: The trap output is 0 at levels 1, 2 and 3 for every target, and 0 at every level for target codes 9 to 15.
- R11: evt_en follows bit 2, evt_fall follows bit 3 (1 = falling edge of the trigger bit), and evt_sel follows bits 7:4 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_lvl | input | 2 | Current exception level, 0 = EL0 through 3 = EL3 |
| req_valid | input | 1 | Access request to the control word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, 0 when no privileged read is requested |
| ctl_undef | output | 1 | Request to the control word is undefined |
| chk_target | input | 4 | Timer or counter register targeted by an EL0 access |
| trap | output | 1 | The checked access must trap |
| evt_en | output | 1 | Event stream enable |
| evt_fall | output | 1 | Event edge direction, 1 = falling |
| evt_sel | output | 4 | Counter bit that triggers events |

## Verification
The bench builds the block with its default parameters: a 32-bit access word, ten writable bits and a 4-bit target identifier. With a 4-bit identifier, codes 9 to 15 exist on the port, so the "no trap for an unknown target" case can be driven directly. For each of several stored words, the bench sweeps every target at every level and compares the trap output against a model written from the requirements. The chosen words include the ones where only one counter enable is set, which exercise the frequency coupling.

// File: rtl/tmr_kctl_pkg.sv
package tmr_kctl_pkg;

    localparam int unsigned FIELD_W = 10;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned LVL_W   = 2;
    localparam int unsigned ID_W    = 4;

    // Stored control word, most significant field first (bit 9 down to bit 0).
    typedef struct packed {
        logic             p_tmr_en;
        logic             v_tmr_en;
        logic [SEL_W-1:0] evt_sel;
        logic             evt_fall;
        logic             evt_en;
        logic             v_cnt_en;
        logic             p_cnt_en;
    } kctl_t;

    typedef enum logic [ID_W-1:0] {
        TGT_FREQ   = 4'd0,
        TGT_PCNT   = 4'd1,
        TGT_VCNT   = 4'd2,
        TGT_P_CTL  = 4'd3,
        TGT_P_CMP  = 4'd4,
        TGT_P_TVAL = 4'd5,
        TGT_V_CTL  = 4'd6,
        TGT_V_CMP  = 4'd7,
        TGT_V_TVAL = 4'd8
    } tgt_e;

endpackage

// File: rtl/tmr_kctl_store.sv
module tmr_kctl_store
    import tmr_kctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic               el0_req,
    input  logic               req_write,
    input  logic [FIELD_W-1:0] wdata,
    output kctl_t              ctl
);

    typedef struct packed {
        kctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.ctl = kctl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl = st_q.ctl;

    // R5: a write from EL0 must not disturb the stored word
    a_r5_el0_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (el0_req && req_write) |=> $stable(st_q.ctl));

    // R2: a privileged write lands in the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (st_q.ctl == kctl_t'($past(wdata))));

    // R2/R5: the word changes only because of a privileged write
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(st_q.ctl));

endmodule

// File: rtl/tmr_kctl_trap.sv
module tmr_kctl_trap
    import tmr_kctl_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic [ID_W-1:0]  target,
    input  kctl_t            ctl,
    output logic             trap
);

    logic at_el0;
    logic blocked;

    assign at_el0 = (cur_lvl == '0);

    always_comb begin
        case (tgt_e'(target))
            TGT_FREQ:                          blocked = !(ctl.p_cnt_en || ctl.v_cnt_en);
            TGT_PCNT:                          blocked = !ctl.p_cnt_en;
            TGT_VCNT:                          blocked = !ctl.v_cnt_en;
            TGT_P_CTL, TGT_P_CMP, TGT_P_TVAL:  blocked = !ctl.p_tmr_en;
            TGT_V_CTL, TGT_V_CMP, TGT_V_TVAL:  blocked = !ctl.v_tmr_en;
            default:                           blocked = 1'b0;
        endcase
    end

    assign trap = at_el0 && blocked;

    // R10: no trap above EL0
    always_comb begin
        if (!at_el0) a_r10_priv_no_trap: assert (!trap);
    end

    // R9: frequency access passes when either counter enable is set
    always_comb begin
        if (target == ID_W'(TGT_FREQ) && (ctl.p_cnt_en || ctl.v_cnt_en))
            a_r9_freq_either_enable: assert (!trap);
    end

endmodule

// File: rtl/tmr_kctl_guard.sv
module tmr_kctl_guard
    import tmr_kctl_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cur_lvl,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [REG_W-1:0] req_wdata,
    output logic [REG_W-1:0] rd_data,
    output logic             ctl_undef,
    input  logic [3:0]       chk_target,
    output logic             trap,
    output logic             evt_en,
    output logic             evt_fall,
    output logic [3:0]       evt_sel
);

    localparam int unsigned PAD_W = REG_W - FIELD_W;

    logic  el0_req;
    logic  wr_ok;
    logic  rd_ok;
    kctl_t ctl;
    logic  unused_hi;

    assign unused_hi = ^req_wdata[REG_W-1:FIELD_W];
    assign el0_req   = req_valid && (cur_lvl == '0);
    assign wr_ok     = req_valid && req_write && !el0_req;
    assign rd_ok     = req_valid && !req_write && !el0_req;
    assign ctl_undef = el0_req;
    assign rd_data   = rd_ok ? {{PAD_W{1'b0}}, ctl} : '0;

    tmr_kctl_store i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .el0_req   (el0_req),
        .req_write (req_write),
        .wdata     (req_wdata[FIELD_W-1:0]),
        .ctl       (ctl)
    );

    tmr_kctl_trap i_trap (
        .cur_lvl (cur_lvl),
        .target  (chk_target),
        .ctl     (ctl),
        .trap    (trap)
    );

    assign evt_en   = ctl.evt_en;
    assign evt_fall = ctl.evt_fall;
    assign evt_sel  = ctl.evt_sel;

    // R3: the reserved part of the read data stays zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:FIELD_W] == '0);

    // R5: an EL0 request never returns data
    a_r5_el0_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_lvl == 2'd0) |-> (rd_data == '0));

    // R4: the undefined flag never rises without a request
    a_r4_undef_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !ctl_undef);

endmodule

// File: tb/test_tmr_kctl_guard.sv
module test_tmr_kctl_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_lvl = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        ctl_undef;
    logic [3:0]  chk_target = '0;
    logic        trap;
    logic        evt_en;
    logic        evt_fall;
    logic [3:0]  evt_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cycles = 0;

    always #5 clk = ~clk;

    tmr_kctl_guard i_tmr_kctl_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_lvl    (cur_lvl),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .rd_data    (rd_data),
        .ctl_undef  (ctl_undef),
        .chk_target (chk_target),
        .trap       (trap),
        .evt_en     (evt_en),
        .evt_fall   (evt_fall),
        .evt_sel    (evt_sel)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_trap(logic [1:0] lvl, logic [3:0] id, logic [9:0] w);
        if (lvl != 2'd0) return 1'b0;
        case (id)
            4'd0:             return !w[0] && !w[1];
            4'd1:             return !w[0];
            4'd2:             return !w[1];
            4'd3, 4'd4, 4'd5: return !w[9];
            4'd6, 4'd7, 4'd8: return !w[8];
            default:          return 1'b0;
        endcase
    endfunction

    task automatic idle();
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic do_write(logic [1:0] lvl, logic [31:0] d);
        @(negedge clk);
        cur_lvl = lvl; req_valid = 1'b1; req_write = 1'b1; req_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic do_read(logic [1:0] lvl, output logic [31:0] d, output logic und);
        @(negedge clk);
        cur_lvl = lvl; req_valid = 1'b1; req_write = 1'b0;
        #1;
        d = rd_data;
        und = ctl_undef;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic u;
        do_read(2'd1, d, u);
        check("R1 reset read", d, 32'h0);
        check("R1 reset evt_en", {31'b0, evt_en}, 32'h0);
        for (int id = 0; id < 9; id++) begin
            @(negedge clk);
            cur_lvl = 2'd0; chk_target = 4'(id);
            #1;
            check("R1 reset trap", {31'b0, trap}, 32'h1);
        end
    endtask

    task automatic t_priv_rw();
        logic [31:0] d;
        logic u;
        for (int l = 1; l < 4; l++) begin
            do_write(2'(l), 32'h0000_0155 + 32'(l));
            do_read(2'(l), d, u);
            check("R2 priv readback", d, 32'h0000_0155 + 32'(l));
            check("R4 priv no undef", {31'b0, u}, 32'h0);
        end
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        logic u;
        do_write(2'd2, 32'hFFFF_FC00 | 32'h2A3);
        do_read(2'd3, d, u);
        check("R3 reserved dropped", d, 32'h0000_02A3);
        do_write(2'd1, 32'hFFFF_FFFF);
        do_read(2'd1, d, u);
        check("R3 all ones", d, 32'h0000_03FF);
    endtask

    task automatic t_el0_access();
        logic [31:0] d;
        logic u;
        do_write(2'd1, 32'h0000_0123);
        @(negedge clk);
        cur_lvl = 2'd0; req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'h0000_03FF;
        #1;
        check("R4 el0 write undef", {31'b0, ctl_undef}, 32'h1);
        @(negedge clk);
        idle();
        do_read(2'd0, d, u);
        check("R4 el0 read undef", {31'b0, u}, 32'h1);
        check("R5 el0 read data", d, 32'h0);
        do_read(2'd1, d, u);
        check("R5 el0 write ignored", d, 32'h0000_0123);
        @(negedge clk);
        cur_lvl = 2'd0;
        #1;
        check("R4 no request no undef", {31'b0, ctl_undef}, 32'h0);
    endtask

    task automatic t_trap_sweep(logic [9:0] w);
        do_write(2'd1, {22'b0, w});
        for (int l = 0; l < 4; l++) begin
            for (int id = 0; id < 16; id++) begin
                @(negedge clk);
                cur_lvl = 2'(l); chk_target = 4'(id);
                #1;
                if (l != 0)
                    check("R10 priv no trap", {31'b0, trap}, 32'h0);
                else if (id == 0)
                    check("R9 freq coupling", {31'b0, trap}, {31'b0, model_trap(2'(l), 4'(id), w)});
                else if (id < 3)
                    check("R8 counter trap", {31'b0, trap}, {31'b0, model_trap(2'(l), 4'(id), w)});
                else if (id < 6)
                    check("R6 phys timer trap", {31'b0, trap}, {31'b0, model_trap(2'(l), 4'(id), w)});
                else if (id < 9)
                    check("R7 virt timer trap", {31'b0, trap}, {31'b0, model_trap(2'(l), 4'(id), w)});
                else
                    check("R10 unknown target", {31'b0, trap}, 32'h0);
            end
        end
    endtask

    task automatic t_event_fields();
        do_write(2'd3, 32'h0000_00AC);
        @(negedge clk);
        check("R11 evt_en", {31'b0, evt_en}, 32'h1);
        check("R11 evt_fall", {31'b0, evt_fall}, 32'h1);
        check("R11 evt_sel", {28'b0, evt_sel}, 32'hA);
        do_write(2'd1, 32'h0000_0050);
        @(negedge clk);
        check("R11 evt_en off", {31'b0, evt_en}, 32'h0);
        check("R11 evt_fall rise", {31'b0, evt_fall}, 32'h0);
        check("R11 evt_sel 5", {28'b0, evt_sel}, 32'h5);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_priv_rw();
        t_reserved();
        t_el0_access();
        t_trap_sweep(10'h000);
        t_trap_sweep(10'h001);
        t_trap_sweep(10'h002);
        t_trap_sweep(10'h100);
        t_trap_sweep(10'h200);
        t_trap_sweep(10'h3FF);
        t_event_fields();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule